// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

Two independent counting units, each holding a low and a high count byte, configured by one mode byte and one control byte behind a small register read/write port. Each unit either counts core clock cycles (one per cycle, no prescaler) or falling edges on its own external count pin, and can be gated by its own external gate pin. Four count shapes are available per unit: a 13-bit count, a 16-bit count, an 8-bit count that reloads itself from the high byte, and a split shape. Each unit raises an overflow flag for an interrupt controller. The controller clears a flag with a one-cycle acknowledge.

The mode field of each unit acts as its state. The states are `MODE_W13`, `MODE_W16`, `MODE_RLD8` and `MODE_SPLIT`. Every transition is a software write to the mode byte, and any state can be reached from any other in one write. Two transitions change how the units work together. When unit 0 enters `MODE_SPLIT`, its high byte becomes an extra 8-bit core-cycle counter. That counter is run by unit 1's run bit, and unit 1's flag is taken over by it. When unit 0 leaves `MODE_SPLIT`, unit 1 gets its own flag back. Unit 1 entering `MODE_SPLIT` freezes unit 1.

Register map (3-bit address): 0 = mode byte, 1 = control byte, 2 = unit 0 low byte, 3 = unit 0 high byte, 4 = unit 1 low byte, 5 = unit 1 high byte. Addresses 6 and 7 read 0. Mode byte: bits [1:0] unit 0 mode (0 = 13-bit, 1 = 16-bit, 2 = reload, 3 = split), bit 2 unit 0 source (1 = count pin), bit 3 unit 0 gate enable, bits [5:4] unit 1 mode, bit 6 unit 1 source, bit 7 unit 1 gate enable. Control byte: bit 0 unit 0 run, bit 1 unit 0 flag, bit 2 unit 1 run, bit 3 unit 1 flag. All other control bits read 0.

Top module: `tmr_pair`

## Requirements
- R1: After reset, all six registers read 0 and both flag outputs are 0.
- R2: A unit advances only when its run bit (control bit 0 or 2) is 1 and either its gate enable (mode bit 3 or 7) is 0 or its gate pin, after a two-flop synchroniser, is high.
- R3: With source bit 0, an enabled unit advances by exactly one on every core clock, starting at the first edge after the write that sets run.
- R4: With source bit 1, an enabled unit advances by one for each falling edge of its count pin, seen through a two-flop synchroniser, however long the pin stays low.
- R5: In mode 0 the count is {high byte, low byte bits [4:0]}. Low byte bits [7:5] keep their written value. The step from 0x1FFF to 0 sets the flag.
- R6: In mode 1 the count is {high byte, low byte}. The step from 0xFFFF to 0 sets the flag.
- R7: In mode 2 only the low byte counts. Its step from 0xFF loads it with the high byte and sets the flag. The high byte is unchanged.
- R8: While run is 0 the count bytes hold. Writing run = 1 does not clear them.
- R9: Unit 1 in mode 3 holds both of its bytes even with run set.
- R10: With unit 0 in mode 3, unit 0's low byte is an 8-bit counter using unit 0's controls and flag. Unit 0's high byte counts core cycles while unit 1's run bit is 1, and its step from 0xFF sets unit 1's flag.
- R11: With unit 0 in mode 3, unit 1 still counts in modes 0 to 2, but its own rollover does not set unit 1's flag.
- R12: A flag is cleared by writing 0 to its control bit or by a one-cycle acknowledge, and set by writing 1. A hardware set in the same cycle as either clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | ADDR_W (3) | Register address |
| reg_wr | input | 1 | Write strobe, one byte per cycle |
| reg_wdata | input | REG_W (8) | Write data |
| reg_rdata | output | REG_W (8) | Read data for reg_addr, combinational |
| t0_gate_pin | input | 1 | Unit 0 external gate |
| t1_gate_pin | input | 1 | Unit 1 external gate |
| t0_count_pin | input | 1 | Unit 0 external count input |
| t1_count_pin | input | 1 | Unit 1 external count input |
| t0_flag_ack | input | 1 | Clears unit 0 flag |
| t1_flag_ack | input | 1 | Clears unit 1 flag |
| t0_ovf_flag | output | 1 | Unit 0 overflow flag |
| t1_ovf_flag | output | 1 | Unit 1 overflow flag |

## Verification
A register write takes effect at the edge where it is sampled. Core-clock counting therefore begins one edge after the run write, and the run-clear write itself still counts once. A run of N cycles from the write of run = 1 to the write of run = 0 therefore yields exactly N steps. A count-pin fall is counted at the second edge after the edge that first samples the low level, and a gate-pin change acts two edges late. The bench waits at least four cycles after each pin change. A flag is set at the same edge as the rollover that causes it. The bench stops each run by rewriting the flag bit with the value it observes one cycle before the stop. Because set wins, the flag is then correct whether the rollover lands at that edge or earlier. Reads are combinational and are sampled 1 ns after a falling edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        MODE_W13   = 2'd0,
        MODE_W16   = 2'd1,
        MODE_RLD8  = 2'd2,
        MODE_SPLIT = 2'd3
    } tmr_mode_e;

    localparam int A_CFG = 0;
    localparam int A_CTL = 1;
    localparam int A_LO0 = 2;
    localparam int A_HI0 = 3;
    localparam int A_LO1 = 4;
    localparam int A_HI1 = 5;

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1,
    parameter bit   FALL    = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic sig
);
    logic [STAGES:0] shift_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shift_q <= {(STAGES+1){RST_VAL}};
        else        shift_q <= {shift_q[STAGES-1:0], pin_in};
    end

    generate
        if (FALL) begin : g_fall
            assign sig = shift_q[STAGES] & ~shift_q[STAGES-1];
        end else begin : g_level
            assign sig = shift_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set,
    input  logic sw_wr,
    input  logic sw_val,
    input  logic ack,
    output logic flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      flag <= 1'b0;
        else if (hw_set) flag <= 1'b1;
        else if (sw_wr)  flag <= sw_val;
        else if (ack)    flag <= 1'b0;
    end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int REG_W      = 8,
    parameter int LOW_PART_W = 5,
    parameter bit IS_T0      = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tmr_mode_e        mode,
    input  logic             step,
    input  logic             hi_step,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] lo,
    output logic [REG_W-1:0] hi,
    output logic             ovf_main,
    output logic             ovf_hi
);
    localparam int NARROW_W = REG_W + LOW_PART_W;
    localparam int WIDE_W   = 2 * REG_W;

    logic [NARROW_W-1:0] narrow_cur, narrow_inc;
    logic [WIDE_W-1:0]   wide_cur, wide_inc;
    logic [REG_W-1:0]    lo_inc, hi_inc, lo_n, hi_n;
    logic [REG_W-1:0]    split_lo, split_hi;
    logic                split_ovf_lo, split_ovf_hi;

    assign narrow_cur = {hi, lo[LOW_PART_W-1:0]};
    assign narrow_inc = narrow_cur + NARROW_W'(1);
    assign wide_cur   = {hi, lo};
    assign wide_inc   = wide_cur + WIDE_W'(1);
    assign lo_inc     = lo + REG_W'(1);
    assign hi_inc     = hi + REG_W'(1);

    // high byte of the split shape: only unit 0 is ever given a hi_step
    assign split_hi     = hi_step ? hi_inc : hi;
    assign split_ovf_hi = hi_step & (&hi);

    generate
        if (IS_T0) begin : g_split_count
            assign split_lo     = step ? lo_inc : lo;
            assign split_ovf_lo = step & (&lo);
        end else begin : g_split_freeze
            assign split_lo     = lo;
            assign split_ovf_lo = 1'b0;
        end
    endgenerate

    always_comb begin
        lo_n     = lo;
        hi_n     = hi;
        ovf_main = 1'b0;
        ovf_hi   = 1'b0;
        unique case (mode)
            MODE_W13: begin
                if (step) begin
                    hi_n                 = narrow_inc[NARROW_W-1:LOW_PART_W];
                    lo_n[LOW_PART_W-1:0] = narrow_inc[LOW_PART_W-1:0];
                    ovf_main             = &narrow_cur;
                end
            end
            MODE_W16: begin
                if (step) begin
                    {hi_n, lo_n} = wide_inc;
                    ovf_main     = &wide_cur;
                end
            end
            MODE_RLD8: begin
                if (step) begin
                    lo_n     = (&lo) ? hi : lo_inc;
                    ovf_main = &lo;
                end
            end
            MODE_SPLIT: begin
                lo_n     = split_lo;
                hi_n     = split_hi;
                ovf_main = split_ovf_lo;
                ovf_hi   = split_ovf_hi;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo <= '0;
            hi <= '0;
        end else begin
            lo <= wr_lo ? wdata : lo_n;
            hi <= wr_hi ? wdata : hi_n;
        end
    end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
    import tmr_pkg::*;
#(
    parameter int REG_W       = 8,
    parameter int LOW_PART_W  = 5,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              t0_gate_pin,
    input  logic              t1_gate_pin,
    input  logic              t0_count_pin,
    input  logic              t1_count_pin,
    input  logic              t0_flag_ack,
    input  logic              t1_flag_ack,
    output logic              t0_ovf_flag,
    output logic              t1_ovf_flag
);
    localparam int UNITS = 2;

    logic [REG_W-1:0] cfg_q;
    logic [UNITS-1:0] run_q, sel_v, gate_v, gate_lvl, cnt_fall, step_v;
    logic [UNITS-1:0] hi_step_v, ovf_main, ovf_hi, set_v, flag_v, ack_v;
    logic [UNITS-1:0] gate_pins, cnt_pins;
    logic [REG_W-1:0] lo_v [UNITS];
    logic [REG_W-1:0] hi_v [UNITS];
    tmr_mode_e        mode_v [UNITS];
    logic             wr_cfg, wr_ctl, t0_split;

    assign gate_pins = {t1_gate_pin, t0_gate_pin};
    assign cnt_pins  = {t1_count_pin, t0_count_pin};
    assign ack_v     = {t1_flag_ack, t0_flag_ack};
    assign wr_cfg    = reg_wr && (reg_addr == ADDR_W'(A_CFG));
    assign wr_ctl    = reg_wr && (reg_addr == ADDR_W'(A_CTL));
    assign t0_split  = (mode_v[0] == MODE_SPLIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            run_q <= '0;
        end else begin
            if (wr_cfg) cfg_q <= reg_wdata;
            if (wr_ctl) run_q <= {reg_wdata[2], reg_wdata[0]};
        end
    end

    generate
        for (genvar u = 0; u < UNITS; u++) begin : g_unit
            assign mode_v[u] = tmr_mode_e'(cfg_q[4*u+1 -: 2]);
            assign sel_v[u]  = cfg_q[4*u+2];
            assign gate_v[u] = cfg_q[4*u+3];

            tmr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0), .FALL(1'b0)) u_gate_sync (
                .clk(clk), .rst_n(rst_n), .pin_in(gate_pins[u]), .sig(gate_lvl[u]));
            tmr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1), .FALL(1'b1)) u_cnt_sync (
                .clk(clk), .rst_n(rst_n), .pin_in(cnt_pins[u]), .sig(cnt_fall[u]));

            assign step_v[u] = run_q[u] & (~gate_v[u] | gate_lvl[u])
                             & (sel_v[u] ? cnt_fall[u] : 1'b1);

            if (u == 0) begin : g_hi_step_t0
                assign hi_step_v[u] = t0_split & run_q[1];
            end else begin : g_hi_step_t1
                assign hi_step_v[u] = 1'b0;
            end

            tmr_unit #(.REG_W(REG_W), .LOW_PART_W(LOW_PART_W), .IS_T0(u == 0)) u_cnt (
                .clk(clk), .rst_n(rst_n), .mode(mode_v[u]),
                .step(step_v[u]), .hi_step(hi_step_v[u]),
                .wr_lo(reg_wr && (reg_addr == ADDR_W'(A_LO0 + 2*u))),
                .wr_hi(reg_wr && (reg_addr == ADDR_W'(A_HI0 + 2*u))),
                .wdata(reg_wdata), .lo(lo_v[u]), .hi(hi_v[u]),
                .ovf_main(ovf_main[u]), .ovf_hi(ovf_hi[u]));

            tmr_flag u_flag (
                .clk(clk), .rst_n(rst_n), .hw_set(set_v[u]),
                .sw_wr(wr_ctl), .sw_val(reg_wdata[2*u+1]),
                .ack(ack_v[u]), .flag(flag_v[u]));
        end
    endgenerate

    // flag routing: unit 1's flag follows unit 0's high byte in split shape
    assign set_v[0] = ovf_main[0];
    assign set_v[1] = t0_split ? ovf_hi[0] : (ovf_main[1] | ovf_hi[1]);

    assign t0_ovf_flag = flag_v[0];
    assign t1_ovf_flag = flag_v[1];

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(A_CFG): reg_rdata = cfg_q;
            ADDR_W'(A_CTL): reg_rdata[3:0] = {flag_v[1], run_q[1], flag_v[0], run_q[0]};
            ADDR_W'(A_LO0): reg_rdata = lo_v[0];
            ADDR_W'(A_HI0): reg_rdata = hi_v[0];
            ADDR_W'(A_LO1): reg_rdata = lo_v[1];
            ADDR_W'(A_HI1): reg_rdata = hi_v[1];
            default:        reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk #(
    parameter int REG_W  = 8,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [1:0]        t0_mode,
    input logic [1:0]        t1_mode,
    input logic              t0_run,
    input logic              t1_run,
    input logic              t0_gate,
    input logic              t0_sel,
    input logic [REG_W-1:0]  t0_lo,
    input logic [REG_W-1:0]  t0_hi,
    input logic [REG_W-1:0]  t1_lo,
    input logic [REG_W-1:0]  t1_hi,
    input logic              t0_set,
    input logic              t1_set,
    input logic              t0_hi_ovf,
    input logic              t0_ack,
    input logic              t0_flag,
    input logic              t1_flag
);
    logic wr_ctl, wr_c0, wr_c1;
    assign wr_ctl = reg_wr && (reg_addr == ADDR_W'(1));
    assign wr_c0  = reg_wr && ((reg_addr == ADDR_W'(2)) || (reg_addr == ADDR_W'(3)));
    assign wr_c1  = reg_wr && ((reg_addr == ADDR_W'(4)) || (reg_addr == ADDR_W'(5)));

    p_core_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (t0_run && !t0_gate && !t0_sel && t0_mode == 2'd1 && !wr_c0)
        |=> ({t0_hi, t0_lo} == $past({t0_hi, t0_lo}) + (2*REG_W)'(1)));

    p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (t0_mode == 2'd2 && t0_set && !wr_c0)
        |=> (t0_lo == $past(t0_hi)) && $stable(t0_hi));

    p_stop_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!t0_run && !t1_run && !wr_c0) |=> $stable({t0_hi, t0_lo}));

    p_t1_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (t1_mode == 2'd3 && !wr_c1) |=> $stable({t1_hi, t1_lo}));

    p_no_own_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (t0_mode == 2'd3 && !t0_hi_ovf && !t1_flag && !wr_ctl) |=> !t1_flag);

    p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        t0_set |=> t0_flag);

    p_set_wins_t1_r12: assert property (@(posedge clk) disable iff (!rst_n)
        t1_set |=> t1_flag);

    p_ack_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (t0_ack && !t0_set && !wr_ctl) |=> !t0_flag);
endmodule

bind tmr_pair tmr_pair_chk #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .t0_mode(cfg_q[1:0]), .t1_mode(cfg_q[5:4]),
    .t0_run(run_q[0]), .t1_run(run_q[1]),
    .t0_gate(gate_v[0]), .t0_sel(sel_v[0]),
    .t0_lo(lo_v[0]), .t0_hi(hi_v[0]), .t1_lo(lo_v[1]), .t1_hi(hi_v[1]),
    .t0_set(set_v[0]), .t1_set(set_v[1]), .t0_hi_ovf(ovf_hi[0]),
    .t0_ack(t0_flag_ack), .t0_flag(flag_v[0]), .t1_flag(flag_v[1]));

// File: tb/tmr_pair_tb.sv
`timescale 1ns/1ps
module tmr_pair_tb;
    localparam int A_CFG = 0, A_CTL = 1, A_LO0 = 2, A_HI0 = 3, A_LO1 = 4, A_HI1 = 5;
    localparam int NVEC = 7;
    // {cfg, hi, lo, cycles, exp_hi, exp_lo, exp_flag0}
    localparam logic [48:0] VEC [NVEC] = '{
        {8'h01, 8'h00, 8'hF0, 8'd5, 8'h00, 8'hF5, 1'b0},
        {8'h01, 8'hFF, 8'hFE, 8'd3, 8'h00, 8'h01, 1'b1},
        {8'h00, 8'hFF, 8'hFE, 8'd3, 8'h00, 8'hE1, 1'b1},
        {8'h00, 8'h00, 8'hBF, 8'd2, 8'h01, 8'hA1, 1'b0},
        {8'h02, 8'h80, 8'hFE, 8'd4, 8'h80, 8'h82, 1'b1},
        {8'h02, 8'h10, 8'h00, 8'd7, 8'h10, 8'h07, 1'b0},
        {8'h03, 8'h00, 8'hFF, 8'd2, 8'h00, 8'h01, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       t0_gate_pin = 1'b0, t1_gate_pin = 1'b0;
    logic       t0_count_pin = 1'b1, t1_count_pin = 1'b1;
    logic       t0_flag_ack = 1'b0, t1_flag_ack = 1'b0;
    logic       t0_ovf_flag, t1_ovf_flag;
    int         checks = 0;
    int         errors = 0;

    always #4 clk = ~clk;

    tmr_pair u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .t0_gate_pin(t0_gate_pin), .t1_gate_pin(t1_gate_pin),
        .t0_count_pin(t0_count_pin), .t1_count_pin(t1_count_pin),
        .t0_flag_ack(t0_flag_ack), .t1_flag_ack(t1_flag_ack),
        .t0_ovf_flag(t0_ovf_flag), .t1_ovf_flag(t1_ovf_flag));

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    // called at a falling edge; the write lands at the next rising edge
    task automatic wr(input int a, input logic [7:0] d);
        reg_addr = 3'(a); reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] v);
        reg_addr = 3'(a);
        #1;
        v = reg_rdata;
    endtask

    // run unit 0 for exactly n core steps, keeping its flag through the stop write
    task automatic run_t0(input int n);
        logic f;
        wr(A_CTL, 8'h01);
        repeat (n - 1) @(negedge clk);
        f = t0_ovf_flag;
        wr(A_CTL, {6'b0, f, 1'b0});
    endtask

    task automatic run_t1(input int n);
        logic f;
        wr(A_CTL, 8'h04);
        repeat (n - 1) @(negedge clk);
        f = t1_ovf_flag;
        wr(A_CTL, {4'b0, f, 3'b0});
    endtask

    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'd0:    return "R3 R5";
            2'd1:    return "R3 R6";
            2'd2:    return "R3 R7";
            default: return "R10";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 6; a++) begin
            rd(a, v);
            chk("R1 register after reset", v, 8'h00);
        end
        chk("R1 flag0 after reset", {7'b0, t0_ovf_flag}, 8'h00);
        chk("R1 flag1 after reset", {7'b0, t1_ovf_flag}, 8'h00);

        // vector table over the count shapes of unit 0
        for (int i = 0; i < NVEC; i++) begin
            logic [48:0] e;
            e = VEC[i];
            wr(A_CTL, 8'h00);
            wr(A_CFG, e[48:41]);
            wr(A_HI0, e[40:33]);
            wr(A_LO0, e[32:25]);
            run_t0(int'(e[24:17]));
            rd(A_HI0, v); chk(mode_tag(e[42:41]), v, e[16:9]);
            rd(A_LO0, v); chk(mode_tag(e[42:41]), v, e[8:1]);
            chk(mode_tag(e[42:41]), {7'b0, t0_ovf_flag}, {7'b0, e[0]});
        end

        // R2: gate enable with gate pin low blocks, high allows
        wr(A_CTL, 8'h00);
        wr(A_CFG, 8'h09);
        wr(A_LO0, 8'h00); wr(A_HI0, 8'h00);
        wr(A_CTL, 8'h01);
        repeat (8) @(negedge clk);
        wr(A_CTL, 8'h00);
        rd(A_LO0, v); chk("R2 gated low no count", v, 8'h00);
        t0_gate_pin = 1'b1;
        repeat (4) @(negedge clk);
        run_t0(4);
        rd(A_LO0, v); chk("R2 gate high counts", v, 8'h04);
        t0_gate_pin = 1'b0;
        repeat (4) @(negedge clk);

        // R4: external falling edges
        wr(A_CFG, 8'h05);
        wr(A_LO0, 8'h00); wr(A_HI0, 8'h00);
        wr(A_CTL, 8'h01);
        for (int p = 0; p < 3; p++) begin
            t0_count_pin = 1'b0;
            repeat (p == 0 ? 10 : 4) @(negedge clk);
            t0_count_pin = 1'b1;
            repeat (4) @(negedge clk);
        end
        wr(A_CTL, 8'h00);
        rd(A_LO0, v); chk("R4 three pin falls", v, 8'h03);
        rd(A_HI0, v); chk("R4 high byte untouched", v, 8'h00);

        // R8: hold while stopped, run does not clear
        wr(A_CFG, 8'h01);
        wr(A_LO0, 8'h40); wr(A_HI0, 8'h12);
        repeat (5) @(negedge clk);
        rd(A_LO0, v); chk("R8 stopped low holds", v, 8'h40);
        run_t0(2);
        rd(A_LO0, v); chk("R8 run keeps count low", v, 8'h42);
        rd(A_HI0, v); chk("R8 run keeps count high", v, 8'h12);

        // R6 on unit 1, flag set when unit 0 not split
        wr(A_CTL, 8'h00);
        wr(A_CFG, 8'h10);
        wr(A_LO1, 8'hFF); wr(A_HI1, 8'hFF);
        run_t1(2);
        rd(A_LO1, v); chk("R6 unit1 wrap low", v, 8'h01);
        chk("R6 unit1 flag", {7'b0, t1_ovf_flag}, 8'h01);

        // R9: unit 1 in split shape freezes
        wr(A_CTL, 8'h00);
        wr(A_CFG, 8'h30);
        wr(A_LO1, 8'h33); wr(A_HI1, 8'h44);
        wr(A_CTL, 8'h04);
        repeat (6) @(negedge clk);
        wr(A_CTL, 8'h00);
        rd(A_LO1, v); chk("R9 unit1 low frozen", v, 8'h33);
        rd(A_HI1, v); chk("R9 unit1 high frozen", v, 8'h44);

        // R10: unit 0 high byte runs on unit 1 run bit, sets unit 1 flag
        wr(A_CFG, 8'h03);
        wr(A_LO0, 8'h10); wr(A_HI0, 8'hFE);
        wr(A_LO1, 8'h00); wr(A_HI1, 8'h00);
        run_t1(3);
        rd(A_HI0, v); chk("R10 split high count", v, 8'h01);
        rd(A_LO0, v); chk("R10 split low idle", v, 8'h10);
        chk("R10 flag1 from split high", {7'b0, t1_ovf_flag}, 8'h01);
        chk("R10 flag0 untouched", {7'b0, t0_ovf_flag}, 8'h00);
        rd(A_LO1, v); chk("R11 unit1 still counts", v, 8'h03);

        // R11: unit 1 rollover does not set its flag while unit 0 is split
        wr(A_CTL, 8'h00);
        wr(A_CFG, 8'h13);
        wr(A_HI0, 8'h00);
        wr(A_LO1, 8'hFE); wr(A_HI1, 8'hFF);
        run_t1(3);
        rd(A_LO1, v); chk("R11 unit1 wrapped low", v, 8'h01);
        rd(A_HI1, v); chk("R11 unit1 wrapped high", v, 8'h00);
        rd(A_HI0, v); chk("R11 split high counted", v, 8'h03);
        chk("R11 flag1 stays clear", {7'b0, t1_ovf_flag}, 8'h00);

        // R12: software set, ack clear, write clear, set wins
        wr(A_CFG, 8'h02);
        wr(A_CTL, 8'h02);
        chk("R12 software set", {7'b0, t0_ovf_flag}, 8'h01);
        t0_flag_ack = 1'b1;
        @(negedge clk);
        t0_flag_ack = 1'b0;
        chk("R12 ack clears", {7'b0, t0_ovf_flag}, 8'h00);
        wr(A_CTL, 8'h02);
        wr(A_CTL, 8'h00);
        chk("R12 write zero clears", {7'b0, t0_ovf_flag}, 8'h00);

        wr(A_HI0, 8'h00); wr(A_LO0, 8'hFE);
        wr(A_CTL, 8'h01);
        @(negedge clk);
        wr(A_CTL, 8'h01);
        chk("R12 set beats write clear", {7'b0, t0_ovf_flag}, 8'h01);
        wr(A_CTL, 8'h00);
        wr(A_LO0, 8'hFE);
        wr(A_CTL, 8'h01);
        @(negedge clk);
        t0_flag_ack = 1'b1;
        @(negedge clk);
        t0_flag_ack = 1'b0;
        chk("R12 set beats ack", {7'b0, t0_ovf_flag}, 8'h01);
        wr(A_CTL, 8'h02);
        rd(A_LO0, v); chk("R7 reload after set race", v, 8'h01);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule